// File: doc/BRIEF.md
# Relay Auto-Tuner for a Digital Buck Compensator

This block runs the tuning sequence of a digitally controlled buck converter's compensator. It sits beside the error path. After a start pulse it switches a one-bit relay into the loop so that the loop settles into a sustained limit cycle. It then sets the compensator to a pure integrator, and the loop oscillates at the power stage's resonance. The block measures that period and uses it to place the first zero. Next it searches for the second zero one step at a time until the oscillation period reaches a target crossover period. Finally it computes the gain from a bandwidth target and the two zero locations.

The only measured quantity is the period of the oscillation. The block finds it by counting valid samples between rising zero crossings of the error word, averaged over eight periods. The size of the error never enters any result. When the sequence ends, the block releases the relay and returns the compensator to linear operation. It also raises `done`. If the second-zero search does not converge within its iteration budget, it raises `tuneErr` as well.

Top module: `relay_autotuner`

## Requirements
- R1: After reset the block is idle: `relayEn`=0, `relayBit`=0, `compMode`=0, `done`=0, `tuneErr`=0, and all three coefficients are 0.
- R2: While tuning, `relayEn`=1 and `relayBit` equals 1 when the most recent valid sample was strictly greater than zero, and 0 otherwise. Outside tuning both are 0.
- R3: `compMode` encodes the compensator setting: 0 = linear (idle or finished), 1 = pure integrator (from start until the first-zero period is taken), 2 = trial PID (second-zero search and gain setting). The value 3 never appears.
- R4: A period is the number of valid samples between two rising crossings, where a rising crossing is a change from a sample that is not above zero to one that is above zero. Each measurement waits for one crossing to synchronise, then averages the next 8 periods. Cycles without `sampleValid` are not counted.
- R5: `z1Coef` is loaded with the averaged period measured in integrator mode, and it stays frozen during the second-zero search.
- R6: The second-zero search starts at `z2Coef`=40. After each measurement, the search has converged if |period − `targetPeriod`| ≤ 1. Otherwise `z2Coef` moves down by 4 if the period is above the target, or up by 4 if it is below, clamped to the range 1..4095, and a new measurement begins.
- R7: If 32 measurements pass without convergence, the block finishes with `tuneErr`=1 and `done`=1, and `gainCoef` keeps its previous value.
- R8: On convergence, `gainCoef` = min(4095, (`gainTarget` × (`z1Coef` + `z2Coef`)) >> 4).
- R9: After completion, `done`=1, the relay is off, and the coefficients hold. A start pulse then restarts the sequence, clearing `done` and `tuneErr` on the next cycle.
- R10: A start pulse while tuning is in progress has no effect.
- R11: The amplitude of the error samples has no effect on any coefficient. Only the timing of sign changes matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `errIn` for this cycle |
| errIn | input | 16 | Signed sampled output error |
| start | input | 1 | Begin a tuning run (used when idle or finished) |
| targetPeriod | input | 12 | Target crossover period in samples |
| gainTarget | input | 8 | Bandwidth target used in the gain computation |
| relayEn | output | 1 | Relay inserted in the loop (tuning active) |
| relayBit | output | 1 | One-bit relay command |
| compMode | output | 2 | Compensator setting (0 linear, 1 integrator, 2 trial PID) |
| z1Coef | output | 12 | First zero, as a period in samples |
| z2Coef | output | 12 | Second zero, as a period in samples |
| gainCoef | output | 12 | Compensator gain |
| done | output | 1 | Tuning finished |
| tuneErr | output | 1 | Second-zero search did not converge |

## Verification
The bench models the loop: it produces a square-wave error whose period follows `compMode` and `z2Coef`, so the search closes on real feedback. The measurement is checked with `sampleValid` held high and also with it toggling every other cycle. A meter that counted clocks instead of samples would double the first zero. The bench drives a target the search cannot reach, and a design that stopped at the wrong iteration, or updated the gain on failure, shows the wrong `z2Coef` or a changed gain. The gain is also checked at its saturating corner and at a target met on the first measurement. A mid-run start pulse, and error amplitudes that vary widely, must leave the results unchanged.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEGRATE,
    ST_MEASURE_F0,
    ST_SET_Z1,
    ST_ITER_Z2,
    ST_SET_GAIN,
    ST_DONE
  } tuneState_t;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_INTEG  = 2'd1,
    MODE_TRIAL  = 2'd2
  } compMode_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_SYNC,
    M_RUN
  } meterPhase_t;

  typedef struct packed {
    logic meterClear;
    logic loadZ1;
    logic initZ2;
    logic stepUp;
    logic stepDown;
    logic loadGain;
  } dpCtrl_t;

endpackage

// File: rtl/tuner_period_meter.sv
module tuner_period_meter
  import tuner_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int AVG_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             errPos,
  input  logic             clear,
  output logic             measDone,
  output logic [PER_W-1:0] measPeriod
);

  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SUM_W = PER_W + AVG_LOG2;
  localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};

  meterPhase_t        phaseQ;
  logic               prevPos;
  logic [PER_W-1:0]   cntQ;
  logic [SUM_W-1:0]   sumQ;
  logic [AVG_LOG2-1:0] edgeQ;

  logic             risingEdge;
  logic [PER_W-1:0] curLen;
  logic [SUM_W-1:0] sumNext;

  // a rising crossing: previous valid sample not above zero, this one above
  assign risingEdge = sampleValid && !prevPos && errPos;
  assign curLen     = (cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1;
  assign sumNext    = sumQ + SUM_W'(curLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ     <= M_IDLE;
      prevPos    <= 1'b1;
      cntQ       <= '0;
      sumQ       <= '0;
      edgeQ      <= '0;
      measDone   <= 1'b0;
      measPeriod <= '0;
    end else begin
      measDone <= 1'b0;
      if (sampleValid) prevPos <= errPos;
      if (clear) begin
        phaseQ <= M_SYNC;
        cntQ   <= '0;
        sumQ   <= '0;
        edgeQ  <= '0;
      end else begin
        case (phaseQ)
          M_SYNC: begin
            if (risingEdge) begin
              phaseQ <= M_RUN;
              cntQ   <= '0;
            end
          end
          M_RUN: begin
            if (sampleValid) begin
              if (risingEdge) begin
                cntQ <= '0;
                sumQ <= sumNext;
                if (edgeQ == AVG_LOG2'(AVG_N - 1)) begin
                  measPeriod <= sumNext[SUM_W-1:AVG_LOG2];
                  measDone   <= 1'b1;
                  phaseQ     <= M_IDLE;
                end else begin
                  edgeQ <= edgeQ + 1'b1;
                end
              end else if (cntQ != CNT_MAX) begin
                cntQ <= cntQ + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tuner_datapath.sv
module tuner_datapath
  import tuner_pkg::*;
#(
  parameter int ERR_W      = 16,
  parameter int PER_W      = 12,
  parameter int GAIN_W     = 8,
  parameter int AVG_LOG2   = 3,
  parameter int Z2_INIT    = 40,
  parameter int Z2_STEP    = 4,
  parameter int Z2_MIN     = 1,
  parameter int TOL        = 1,
  parameter int GAIN_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [ERR_W-1:0]  errIn,
  input  logic              relayEn,
  input  dpCtrl_t           strb,
  input  logic [PER_W-1:0]  targetPeriod,
  input  logic [GAIN_W-1:0] gainTarget,
  output logic              measDone,
  output logic              inTol,
  output logic              aboveTarget,
  output logic              relayBit,
  output logic [PER_W-1:0]  z1Coef,
  output logic [PER_W-1:0]  z2Coef,
  output logic [PER_W-1:0]  gainCoef
);

  localparam int PROD_W = GAIN_W + PER_W + 1;
  localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};
  localparam logic [PER_W-1:0] STEP_V  = PER_W'(Z2_STEP);
  localparam logic [PER_W-1:0] MIN_V   = PER_W'(Z2_MIN);
  localparam logic [PER_W-1:0] INIT_V  = PER_W'(Z2_INIT);

  logic             errPos;
  logic             relayQ;
  logic [PER_W-1:0] measPeriod;
  logic [PER_W:0]   diffAbs;
  logic [PER_W-1:0] z2Up;
  logic [PER_W-1:0] z2Down;
  logic [PER_W:0]   zSum;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [PER_W-1:0] gainNext;

  assign errPos = $signed(errIn) > 0;

  tuner_period_meter #(
    .PER_W   (PER_W),
    .AVG_LOG2(AVG_LOG2)
  ) u_meter (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .errPos     (errPos),
    .clear      (strb.meterClear),
    .measDone   (measDone),
    .measPeriod (measPeriod)
  );

  // one-bit relay quantizer
  always_ff @(posedge clk) begin
    if (!rstN)             relayQ <= 1'b0;
    else if (!relayEn)     relayQ <= 1'b0;
    else if (sampleValid)  relayQ <= errPos;
  end
  assign relayBit = relayEn & relayQ;

  // period versus target comparison
  always_comb begin
    if (measPeriod >= targetPeriod) diffAbs = {1'b0, measPeriod} - {1'b0, targetPeriod};
    else                            diffAbs = {1'b0, targetPeriod} - {1'b0, measPeriod};
  end
  assign inTol       = diffAbs <= (PER_W+1)'(TOL);
  assign aboveTarget = measPeriod > targetPeriod;

  // clamped second-zero steps
  assign z2Up   = (z2Coef > PER_MAX - STEP_V) ? PER_MAX : z2Coef + STEP_V;
  assign z2Down = (z2Coef < MIN_V + STEP_V)   ? MIN_V   : z2Coef - STEP_V;

  // gain from bandwidth target and both zero locations, saturated
  assign zSum     = {1'b0, z1Coef} + {1'b0, z2Coef};
  assign prod     = PROD_W'(gainTarget) * PROD_W'(zSum);
  assign scaled   = prod >> GAIN_SHIFT;
  assign gainNext = (scaled > PROD_W'(PER_MAX)) ? PER_MAX : scaled[PER_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      z1Coef   <= '0;
      z2Coef   <= '0;
      gainCoef <= '0;
    end else begin
      if (strb.loadZ1)        z1Coef   <= measPeriod;
      if (strb.initZ2)        z2Coef   <= INIT_V;
      else if (strb.stepUp)   z2Coef   <= z2Up;
      else if (strb.stepDown) z2Coef   <= z2Down;
      if (strb.loadGain)      gainCoef <= gainNext;
    end
  end

endmodule

// File: rtl/tuner_ctrl.sv
module tuner_ctrl
  import tuner_pkg::*;
#(
  parameter int SETTLE   = 16,
  parameter int MAX_ITER = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      sampleValid,
  input  logic      measDone,
  input  logic      inTol,
  input  logic      aboveTarget,
  output dpCtrl_t   strb,
  output logic      relayEn,
  output logic [1:0] compMode,
  output logic      done,
  output logic      tuneErr
);

  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

  tuneState_t        stateQ, stateD;
  logic [SET_W-1:0]  settleQ;
  logic [ITER_W-1:0] iterQ;
  logic              errQ;
  logic              settleEnd;
  logic              iterLast;
  logic              idleLike;
  compMode_t         modeD;

  assign settleEnd = sampleValid && (settleQ == SET_W'(SETTLE - 1));
  assign iterLast  = (iterQ == ITER_W'(MAX_ITER - 1));
  assign idleLike  = (stateQ == ST_IDLE) || (stateQ == ST_DONE);

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) stateD = ST_INTEGRATE;
      end
      ST_INTEGRATE: begin
        if (settleEnd) begin
          strb.meterClear = 1'b1;
          stateD          = ST_MEASURE_F0;
        end
      end
      ST_MEASURE_F0: begin
        if (measDone) stateD = ST_SET_Z1;
      end
      ST_SET_Z1: begin
        strb.loadZ1     = 1'b1;
        strb.initZ2     = 1'b1;
        strb.meterClear = 1'b1;
        stateD          = ST_ITER_Z2;
      end
      ST_ITER_Z2: begin
        if (measDone) begin
          if (inTol) begin
            stateD = ST_SET_GAIN;
          end else if (iterLast) begin
            stateD = ST_DONE;
          end else begin
            strb.meterClear = 1'b1;
            if (aboveTarget) strb.stepDown = 1'b1;
            else             strb.stepUp   = 1'b1;
          end
        end
      end
      ST_SET_GAIN: begin
        strb.loadGain = 1'b1;
        stateD        = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      settleQ <= '0;
      iterQ   <= '0;
      errQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (idleLike && start) begin
        settleQ <= '0;
        iterQ   <= '0;
        errQ    <= 1'b0;
      end
      if (stateQ == ST_INTEGRATE && sampleValid && !settleEnd)
        settleQ <= settleQ + 1'b1;
      if (stateQ == ST_ITER_Z2 && measDone && !inTol) begin
        if (iterLast) errQ  <= 1'b1;
        else          iterQ <= iterQ + 1'b1;
      end
    end
  end

  always_comb begin
    case (stateQ)
      ST_INTEGRATE, ST_MEASURE_F0:         modeD = MODE_INTEG;
      ST_SET_Z1, ST_ITER_Z2, ST_SET_GAIN:  modeD = MODE_TRIAL;
      default:                             modeD = MODE_LINEAR;
    endcase
  end

  assign compMode = modeD;
  assign relayEn  = !idleLike;
  assign done     = (stateQ == ST_DONE);
  assign tuneErr  = errQ;

endmodule

// File: rtl/relay_autotuner.sv
module relay_autotuner
  import tuner_pkg::*;
#(
  parameter int ERR_W      = 16,
  parameter int PER_W      = 12,
  parameter int GAIN_W     = 8,
  parameter int AVG_LOG2   = 3,
  parameter int SETTLE     = 16,
  parameter int MAX_ITER   = 32,
  parameter int Z2_INIT    = 40,
  parameter int Z2_STEP    = 4,
  parameter int Z2_MIN     = 1,
  parameter int TOL        = 1,
  parameter int GAIN_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [ERR_W-1:0]  errIn,
  input  logic              start,
  input  logic [PER_W-1:0]  targetPeriod,
  input  logic [GAIN_W-1:0] gainTarget,
  output logic              relayEn,
  output logic              relayBit,
  output logic [1:0]        compMode,
  output logic [PER_W-1:0]  z1Coef,
  output logic [PER_W-1:0]  z2Coef,
  output logic [PER_W-1:0]  gainCoef,
  output logic              done,
  output logic              tuneErr
);

  dpCtrl_t strb;
  logic    measDone;
  logic    inTol;
  logic    aboveTarget;

  tuner_ctrl #(
    .SETTLE  (SETTLE),
    .MAX_ITER(MAX_ITER)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleValid(sampleValid),
    .measDone   (measDone),
    .inTol      (inTol),
    .aboveTarget(aboveTarget),
    .strb       (strb),
    .relayEn    (relayEn),
    .compMode   (compMode),
    .done       (done),
    .tuneErr    (tuneErr)
  );

  tuner_datapath #(
    .ERR_W     (ERR_W),
    .PER_W     (PER_W),
    .GAIN_W    (GAIN_W),
    .AVG_LOG2  (AVG_LOG2),
    .Z2_INIT   (Z2_INIT),
    .Z2_STEP   (Z2_STEP),
    .Z2_MIN    (Z2_MIN),
    .TOL       (TOL),
    .GAIN_SHIFT(GAIN_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .errIn       (errIn),
    .relayEn     (relayEn),
    .strb        (strb),
    .targetPeriod(targetPeriod),
    .gainTarget  (gainTarget),
    .measDone    (measDone),
    .inTol       (inTol),
    .aboveTarget (aboveTarget),
    .relayBit    (relayBit),
    .z1Coef      (z1Coef),
    .z2Coef      (z2Coef),
    .gainCoef    (gainCoef)
  );

endmodule

// File: rtl/relay_autotuner_chk.sv
module relay_autotuner_chk #(
  parameter int PER_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             relayEn,
  input logic             relayBit,
  input logic [1:0]       compMode,
  input logic [PER_W-1:0] z1Coef,
  input logic [PER_W-1:0] z2Coef,
  input logic [PER_W-1:0] gainCoef,
  input logic             done,
  input logic             tuneErr
);

  p_done_relay_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!relayEn && !relayBit));

  p_linear_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !relayEn |-> (compMode == 2'd0));

  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    relayEn |-> (compMode == 2'd1 || compMode == 2'd2));

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    tuneErr |-> done);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (relayEn && compMode == 2'd1 && !done && !tuneErr));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (relayEn && compMode == 2'd2 && start) |=> (compMode != 2'd1));

  p_z1_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (compMode == 2'd2 && $past(compMode) == 2'd2 && $past(compMode, 2) == 2'd2)
      |-> $stable(z1Coef));

  p_coef_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> ($stable(z1Coef) && $stable(z2Coef) && $stable(gainCoef)));

  p_gain_on_success_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainCoef) |-> (done && !tuneErr));

endmodule

bind relay_autotuner relay_autotuner_chk #(.PER_W(PER_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .relayEn (relayEn),
  .relayBit(relayBit),
  .compMode(compMode),
  .z1Coef  (z1Coef),
  .z2Coef  (z2Coef),
  .gainCoef(gainCoef),
  .done    (done),
  .tuneErr (tuneErr)
);

// File: tb/relay_autotuner_tb.sv
`timescale 1ns/1ps
module relay_autotuner_tb;

  localparam int ERR_W  = 16;
  localparam int PER_W  = 12;
  localparam int GAIN_W = 8;

  logic              clk;
  logic              rstN;
  logic              sampleValid;
  logic [ERR_W-1:0]  errIn;
  logic              start;
  logic [PER_W-1:0]  targetPeriod;
  logic [GAIN_W-1:0] gainTarget;
  logic              relayEn;
  logic              relayBit;
  logic [1:0]        compMode;
  logic [PER_W-1:0]  z1Coef;
  logic [PER_W-1:0]  z2Coef;
  logic [PER_W-1:0]  gainCoef;
  logic              done;
  logic              tuneErr;

  int total = 0;
  int bad   = 0;

  // loop model controls
  int p0        = 50;
  int phase     = 0;
  int curPer    = 16;
  int amp       = 3;
  bit slowValid = 1'b0;
  bit ampVary   = 1'b0;
  bit vTgl      = 1'b0;
  bit lastPos   = 1'b0;

  relay_autotuner u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .errIn       (errIn),
    .start       (start),
    .targetPeriod(targetPeriod),
    .gainTarget  (gainTarget),
    .relayEn     (relayEn),
    .relayBit    (relayBit),
    .compMode    (compMode),
    .z1Coef      (z1Coef),
    .z2Coef      (z2Coef),
    .gainCoef    (gainCoef),
    .done        (done),
    .tuneErr     (tuneErr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // square-wave loop model: period follows the compensator setting
  always @(negedge clk) begin
    if (!rstN) begin
      phase       = 0;
      sampleValid = 1'b0;
      errIn       = '0;
    end else begin
      if (slowValid) vTgl = ~vTgl;
      else           vTgl = 1'b1;
      sampleValid = vTgl;
      if (compMode == 2'd1)      curPer = p0;
      else if (compMode == 2'd2) curPer = (int'(z2Coef) < 4) ? 4 : int'(z2Coef);
      else                       curPer = 16;
      if (sampleValid) begin
        phase++;
        if (phase >= curPer) phase = 0;
      end
      amp   = ampVary ? 1 + ((phase * 37) % 900) : 3;
      errIn = (phase < curPer / 2) ? ERR_W'(amp) : ERR_W'(-amp);
    end
  end

  always @(posedge clk) if (sampleValid) lastPos <= ($signed(errIn) > 0);

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(input int maxCyc, input string tag);
    int n = 0;
    while (!done && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
    checkEq({tag, " done reached"}, int'(done), 1);
  endtask

  task automatic testReset();
    rstN = 1'b0; start = 1'b0; targetPeriod = '0; gainTarget = '0;
    repeat (4) @(negedge clk);
    checkEq("R1 relayEn", int'(relayEn), 0);
    checkEq("R1 relayBit", int'(relayBit), 0);
    checkEq("R1 compMode", int'(compMode), 0);
    checkEq("R1 done", int'(done), 0);
    checkEq("R1 tuneErr", int'(tuneErr), 0);
    checkEq("R1 coefs", int'(z1Coef) + int'(z2Coef) + int'(gainCoef), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // integrator period 50, target 24: z2 walks 40,36,32,28,24
  task automatic testConverge();
    int mism = 0;
    int n = 0;
    p0 = 50; targetPeriod = 12'd24; gainTarget = 8'd16; ampVary = 1'b1; slowValid = 1'b0;
    pulseStart();
    checkEq("R3 integrator after start", int'(compMode), 1);
    checkEq("R2 relay enabled", int'(relayEn), 1);
    while (compMode != 2'd2 && n < 5000) begin @(negedge clk); n++; end
    checkEq("R3 trial mode reached", int'(compMode), 2);
    // mid-run start must be ignored
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    checkEq("R10 busy start ignored mode", int'(compMode), 2);
    checkEq("R10 busy start relay on", int'(relayEn), 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (relayBit != lastPos) mism++;
    end
    checkEq("R2 relay follows sign", mism, 0);
    waitDone(20000, "R6");
    checkEq("R5 z1 equals f0 period", int'(z1Coef), 50);
    checkEq("R6 z2 converged", int'(z2Coef), 24);
    checkEq("R8 gain", int'(gainCoef), 74);
    checkEq("R7 no error", int'(tuneErr), 0);
    checkEq("R9 relay released", int'(relayEn), 0);
    checkEq("R3 linear after done", int'(compMode), 0);
    checkEq("R11 varying amplitude same result", int'(z2Coef) + int'(z1Coef), 74);
  endtask

  // period 300 with every other sample valid; target met on first try; gain saturates
  task automatic testSatSlowValid();
    p0 = 300; targetPeriod = 12'd40; gainTarget = 8'd255; ampVary = 1'b0; slowValid = 1'b1;
    pulseStart();
    waitDone(30000, "R4");
    checkEq("R4 period in valid samples", int'(z1Coef), 300);
    checkEq("R6 first measurement in tolerance", int'(z2Coef), 40);
    checkEq("R8 gain saturates", int'(gainCoef), 4095);
    slowValid = 1'b0;
  endtask

  // unreachable target: 32 measurements, z2 rises 31 steps
  task automatic testNoConverge();
    p0 = 50; targetPeriod = 12'd400; gainTarget = 8'd16;
    pulseStart();
    waitDone(80000, "R7");
    checkEq("R7 error flag", int'(tuneErr), 1);
    checkEq("R7 z2 after 31 steps", int'(z2Coef), 164);
    checkEq("R7 gain untouched", int'(gainCoef), 4095);
    checkEq("R9 relay off after error", int'(relayEn), 0);
    repeat (10) @(negedge clk);
    checkEq("R9 coefficients hold", int'(z2Coef), 164);
  endtask

  task automatic testRestart();
    targetPeriod = 12'd24; gainTarget = 8'd16; ampVary = 1'b1;
    pulseStart();
    checkEq("R9 restart clears done", int'(done), 0);
    checkEq("R9 restart clears error", int'(tuneErr), 0);
    waitDone(20000, "R9");
    checkEq("R9 rerun z2", int'(z2Coef), 24);
    checkEq("R9 rerun gain", int'(gainCoef), 74);
    checkEq("R9 rerun no error", int'(tuneErr), 0);
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    testReset();
    testConverge();
    testSatSlowValid();
    testNoConverge();
    testRestart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule